// File: doc/BRIEF.md
# Strobe-Controlled FIFO with Read Rewind

This block is a first-in, first-out buffer of 9-bit words. A producer and a consumer request transfers with active-low strobes instead of a clock-qualified handshake. Each strobe passes through a two-stage synchronizer and an edge detector on the system clock. A transfer opens when its strobe falls and closes when its strobe rises. A write stores the word on the data input at the closing edge. A read presents the oldest word on the output, with an output-enable flag, for as long as its strobe stays low. The read pointer advances when the strobe rises.

The block keeps three active-low status flags: full, empty and half-full. A transfer that the flags forbid at its falling edge is ignored for its whole duration. A separate active-low rewind strobe moves the read pointer back to the first storage location. This lets the consumer replay everything written since the last reset, provided that fewer than DEPTH words have been written. The depth is a power-of-two parameter. The pointers are one bit wider than the address, so a completely full buffer and an empty one have different encodings.

Top module: `strobe_fifo`

## Requirements
- R1: While rst_n is low at a clock edge, both pointers return to location 0. After that edge, empty_n is 0, full_n is 1, half_n is 1 and dout_oe is 0.
- R2: A write opens on a falling edge of wr_n only if full_n is 1. It stores din, as sampled when the rising edge of wr_n is detected, at the next sequential location.
- R3: A read opens on a falling edge of rd_n only if empty_n is 1. It drives the oldest stored word on dout with dout_oe at 1, and advances the read pointer at the rising edge of rd_n. Words come out in the order they were written.
- R4: full_n goes to 0 when the occupancy reaches DEPTH. With no reads since reset, this happens on exactly the DEPTH-th write. A write strobe while full changes neither the pointers nor the stored data. full_n returns to 1 once a read completes.
- R5: empty_n is 0 when occupancy is 0. The read that removes the last word still completes. A read strobe while empty leaves dout_oe at 0 and does not move the read pointer. empty_n returns to 1 once a write completes.
- R6: dout_oe is 0 whenever the synchronized rd_n is high. dout_oe is 1 only during an accepted read.
- R7: half_n goes to 0 when a write opens while occupancy is at least DEPTH/2. half_n goes back to 1 when a read completes and leaves occupancy at or below DEPTH/2.
- R8: A falling edge of rt_n, while neither a read nor a write is open, sets the read pointer to location 0 and leaves the write pointer unchanged. All three flags then follow the new occupancy: half_n is 0 exactly when occupancy exceeds DEPTH/2.
- R9: When a write and a read close in the same clock cycle, occupancy is unchanged and first-in, first-out order is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_n | input | 1 | Active-low write strobe |
| rd_n | input | 1 | Active-low read strobe |
| rt_n | input | 1 | Active-low rewind strobe |
| din | input | 9 | Write data |
| dout | output | 9 | Read data |
| dout_oe | output | 1 | High while dout carries an accepted read word |
| full_n | output | 1 | Low when full |
| empty_n | output | 1 | Low when empty |
| half_n | output | 1 | Low when more than half full |

## Verification
The bench runs a mixed sequence of writes, reads and a rewind. It checks dout and every flag after each strobe. This separates a correct half-full hysteresis, which sets on a write start and releases on a read close, from a plain occupancy compare. It also shows that a rewind replays old words. A fill to exactly DEPTH words, followed by a forbidden extra write, shows whether the full condition fires one word early or late and whether data gets overwritten. A drain followed by a forbidden read covers the empty case in the same way. Strobing wr_n and rd_n together checks that completions in the same cycle keep occupancy and order, and a reset in the middle of use checks that the pointers return to location 0.

// File: rtl/strobe_fifo_pkg.sv
package strobe_fifo_pkg;
    localparam int DATA_W = 9;

    typedef logic [DATA_W-1:0] word_t;

    typedef struct packed {
        logic level;
        logic fall;
        logic rise;
    } strobe_ev_t;

    typedef enum logic [1:0] {
        OP_WRITE  = 2'd0,
        OP_READ   = 2'd1,
        OP_REWIND = 2'd2
    } op_e;
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync
    import strobe_fifo_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       strobe_n,
    output strobe_ev_t ev
);
    // sh[0], sh[1]: synchronizer stages; sh[2]: previous synchronized level
    logic [2:0] sh;

    always_ff @(posedge clk) begin
        if (!rst_n) sh <= 3'b111;
        else        sh <= {sh[1:0], strobe_n};
    end

    always_comb begin
        ev.level = sh[1];
        ev.fall  = sh[2] & ~sh[1];
        ev.rise  = ~sh[2] & sh[1];
    end
endmodule

// File: rtl/fifo_store.sv
module fifo_store
    import strobe_fifo_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  word_t         wdata,
    input  logic [AW-1:0] raddr,
    output word_t         rdata
);
    word_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/strobe_fifo.sv
module strobe_fifo
    import strobe_fifo_pkg::*;
#(
    parameter int DEPTH = 1024
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_n,
    input  logic        rd_n,
    input  logic        rt_n,
    input  logic [8:0]  din,
    output logic [8:0]  dout,
    output logic        dout_oe,
    output logic        full_n,
    output logic        empty_n,
    output logic        half_n
);
    localparam int AW   = $clog2(DEPTH);
    localparam int PW   = AW + 1;
    localparam int HALF = DEPTH / 2;
    localparam int NSTB = 3;

    typedef logic [PW-1:0] ptr_t;

    // strobe index: 0 write, 1 read, 2 rewind
    logic [NSTB-1:0] strobes;
    strobe_ev_t      ev [NSTB];

    assign strobes = {rt_n, rd_n, wr_n};

    for (genvar g = 0; g < NSTB; g++) begin : g_sync
        strobe_sync u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .strobe_n (strobes[g]),
            .ev       (ev[g])
        );
    end

    ptr_t  wptr, rptr, wptr_nx, rptr_nx, occ, occ_nx;
    logic  wr_act, rd_act, half_q;
    logic  full, empty;
    logic  wr_go, wr_done, rd_go, rd_done, rt_go;
    word_t rdata;

    assign occ   = wptr - rptr;
    assign full  = (occ == ptr_t'(DEPTH));
    assign empty = (occ == '0);

    assign wr_go   = ev[0].fall & ~full & ~wr_act;
    assign wr_done = ev[0].rise & wr_act;
    assign rd_go   = ev[1].fall & ~empty & ~rd_act;
    assign rd_done = ev[1].rise & rd_act;
    assign rt_go   = ev[2].fall & ~wr_act & ~rd_act & ev[0].level & ev[1].level;

    assign wptr_nx = wptr + ptr_t'(wr_done);
    assign rptr_nx = rt_go ? '0 : rptr + ptr_t'(rd_done);
    assign occ_nx  = wptr_nx - rptr_nx;

    fifo_store #(.DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .we    (wr_done),
        .waddr (wptr[AW-1:0]),
        .wdata (din),
        .raddr (rptr[AW-1:0]),
        .rdata (rdata)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr    <= '0;
            rptr    <= '0;
            wr_act  <= 1'b0;
            rd_act  <= 1'b0;
            half_q  <= 1'b0;
            dout    <= '0;
            dout_oe <= 1'b0;
        end else begin
            wptr <= wptr_nx;
            rptr <= rptr_nx;

            if (wr_go)        wr_act <= 1'b1;
            else if (wr_done) wr_act <= 1'b0;

            if (rd_go) begin
                rd_act  <= 1'b1;
                dout    <= rdata;
                dout_oe <= 1'b1;
            end else if (rd_done || ev[1].level) begin
                rd_act  <= 1'b0;
                dout_oe <= 1'b0;
            end

            if (rt_go)
                half_q <= (occ_nx > ptr_t'(HALF));
            else if (wr_go && occ >= ptr_t'(HALF))
                half_q <= 1'b1;
            else if (rd_done && occ_nx <= ptr_t'(HALF))
                half_q <= 1'b0;
        end
    end

    assign full_n  = ~full;
    assign empty_n = ~empty;
    assign half_n  = ~half_q;
endmodule

// File: rtl/strobe_fifo_chk.sv
module strobe_fifo_chk #(
    parameter int PW = 11
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rd_n,
    input logic          full_n,
    input logic          empty_n,
    input logic          half_n,
    input logic          dout_oe,
    input logic [PW-1:0] wptr,
    input logic [PW-1:0] rptr
);
    // R4: no write pointer movement while full
    a_r4_full_holds_wptr: assert property (@(posedge clk) disable iff (!rst_n)
        !full_n |=> $stable(wptr));

    // R5: while empty the read pointer only moves by a rewind to 0
    a_r5_empty_holds_rptr: assert property (@(posedge clk) disable iff (!rst_n)
        !empty_n |=> (rptr == $past(rptr)) || (rptr == '0));

    // R4 and R5: full and empty never together
    a_r4_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!full_n && !empty_n));

    // R6: output idle after the read strobe has been high for three samples
    a_r6_oe_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rd_n, 1) && $past(rd_n, 2) && $past(rd_n, 3)) |-> !dout_oe);

    // R7: full occupancy is always above half
    a_r7_full_implies_half: assert property (@(posedge clk) disable iff (!rst_n)
        !full_n |-> !half_n);
endmodule

bind strobe_fifo strobe_fifo_chk #(.PW(PW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_n    (rd_n),
    .full_n  (full_n),
    .empty_n (empty_n),
    .half_n  (half_n),
    .dout_oe (dout_oe),
    .wptr    (wptr),
    .rptr    (rptr)
);

// File: tb/tb_strobe_fifo.sv
module tb_strobe_fifo;
    import strobe_fifo_pkg::*;

    localparam int DEPTH = 8;
    localparam int NVEC  = 11;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_n = 1'b1, rd_n = 1'b1, rt_n = 1'b1;
    logic [8:0] din = '0;
    logic [8:0] dout;
    logic       dout_oe, full_n, empty_n, half_n;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    strobe_fifo #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n), .rt_n(rt_n),
        .din(din), .dout(dout), .dout_oe(dout_oe),
        .full_n(full_n), .empty_n(empty_n), .half_n(half_n)
    );

    // vector: op[13:12], data[11:3] (write data or expected read data),
    // expected empty_n, full_n, half_n after the operation [2:0]
    localparam logic [13:0] VEC [NVEC] = '{
        {OP_WRITE,  9'h011, 3'b111},
        {OP_WRITE,  9'h022, 3'b111},
        {OP_READ,   9'h011, 3'b111},
        {OP_WRITE,  9'h033, 3'b111},
        {OP_WRITE,  9'h044, 3'b111},
        {OP_WRITE,  9'h055, 3'b111},
        {OP_WRITE,  9'h066, 3'b110},
        {OP_READ,   9'h022, 3'b111},
        {OP_REWIND, 9'h000, 3'b110},
        {OP_READ,   9'h011, 3'b110},
        {OP_READ,   9'h022, 3'b111}
    };

    task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_write(input logic [8:0] d);
        din = d; wr_n = 1'b0; idle(4);
        wr_n = 1'b1; idle(4);
    endtask

    task automatic do_read(input string tag, input logic [8:0] exp, input logic exp_oe);
        rd_n = 1'b0; idle(4);
        chk({tag, " oe"}, {8'd0, dout_oe}, {8'd0, exp_oe});
        if (exp_oe) chk({tag, " data"}, dout, exp);
        rd_n = 1'b1; idle(4);
        chk({tag, " oe after release R6"}, {8'd0, dout_oe}, 9'd0);
    endtask

    task automatic do_rewind();
        rt_n = 1'b0; idle(4);
        rt_n = 1'b1; idle(4);
    endtask

    task automatic chk_flags(input string tag, input logic [2:0] exp);
        chk(tag, {6'd0, empty_n, full_n, half_n}, {6'd0, exp});
    endtask

    task automatic do_reset();
        rst_n = 1'b0; idle(3);
        rst_n = 1'b1; idle(2);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cycles, 100000);
            finish_run();
        end
    end

    initial begin
        idle(1);
        do_reset();
        // R1: reset state
        chk_flags("R1 flags after reset", 3'b011);
        chk("R1 oe after reset", {8'd0, dout_oe}, 9'd0);

        // table: R2 R3 R7 R8
        for (int i = 0; i < NVEC; i++) begin
            case (op_e'(VEC[i][13:12]))
                OP_WRITE:  do_write(VEC[i][11:3]);
                OP_READ:   do_read($sformatf("R3 vec%0d", i), VEC[i][11:3], 1'b1);
                default:   do_rewind();
            endcase
            chk_flags($sformatf("R7 R8 flags vec%0d", i), VEC[i][2:0]);
        end

        // R4: fill exactly DEPTH, extra write ignored
        do_reset();
        for (int i = 0; i < DEPTH; i++) begin
            chk(((i == DEPTH - 1) ? "R4 not full one early" : "R4 not full"),
                {8'd0, full_n}, 9'd1);
            do_write(9'(9'h100 + i));
        end
        chk("R4 full after DEPTH writes", {8'd0, full_n}, 9'd0);
        do_write(9'h1FF);
        chk("R4 still full after blocked write", {8'd0, full_n}, 9'd0);
        do_read("R4 first read", 9'h100, 1'b1);
        chk("R4 full released by read", {8'd0, full_n}, 9'd1);
        for (int i = 1; i < DEPTH; i++)
            do_read($sformatf("R4 order %0d", i), 9'(9'h100 + i), 1'b1);
        // R5: empty and blocked read
        chk_flags("R5 empty after drain", 3'b011);
        do_read("R5 read while empty", 9'h000, 1'b0);
        chk_flags("R5 still empty", 3'b011);
        do_write(9'h0AA);
        chk("R5 empty released by write", {8'd0, empty_n}, 9'd1);
        do_read("R5 pointer kept", 9'h0AA, 1'b1);

        // R9: simultaneous write and read
        do_write(9'h0C1);
        din = 9'h0C2; wr_n = 1'b0; rd_n = 1'b0; idle(4);
        chk("R9 concurrent read data", dout, 9'h0C1);
        wr_n = 1'b1; rd_n = 1'b1; idle(4);
        chk_flags("R9 occupancy kept", 3'b111);
        do_read("R9 order kept", 9'h0C2, 1'b1);
        chk_flags("R9 empty afterwards", 3'b011);

        // R1: reset during use
        do_write(9'h051);
        do_write(9'h052);
        do_reset();
        chk_flags("R1 flags after mid reset", 3'b011);
        do_write(9'h077);
        do_read("R1 pointers back to 0", 9'h077, 1'b1);

        finish_run();
    end
endmodule